// File: doc/BRIEF.md
# Sense Status Report Generator

This block keeps the error and address state that a disk controller has to report when the host asks for sense. It latches the error code of the last failing command, an address-valid flag, and the drive, head, sector and cylinder of the last addressed operation. It also keeps the completion byte of the command in flight. That byte starts each command with the drive number in its top three bits and gains a failure flag when an error is reported.

When the host starts a report, the block presents four bytes one at a time. Each byte stays on the output until the host takes it. The stored error is cleared when the first byte is produced. A one-cycle done pulse follows the fourth byte. Decoding of commands, the host handshake and media access belong to neighbouring logic. That logic drives the command-begin strobe with its attributes, the failure strobe, the report-start strobe and the byte-taken strobe.

Top module: `sense_report_gen`

## Requirements
- R1: After reset `rpt_valid`, `rpt_done` and `compl_byte` are 0. A report taken straight after reset yields four zero bytes.
- R2: Report byte 0 is the address-valid flag in bit 7, ORed with the stored 6-bit error code in bits 5:0. Bits 5:4 of the code are the error class: 0 drive, 1 controller, 2 command, 3 miscellaneous. Bit 6 is 0.
- R3: Report byte 1 is 0x20 when the latched drive number is nonzero, ORed with the 5-bit head number in bits 4:0.
- R4: Report byte 2 holds cylinder bits 9:8 in bits 7:6, ORed with the 6-bit sector number in bits 5:0. Report byte 3 is cylinder bits 7:0.
- R5: Bytes come out in the order 0, 1, 2, 3. Each byte is held with `rpt_valid` high until a cycle with `rpt_take` high. The next byte appears one cycle after that take.
- R6: The clock edge that takes byte 3 drops `rpt_valid` and raises `rpt_done` for exactly one cycle.
- R7: Producing byte 0 clears the stored error code to 0, so a second report shows code 0.
- R8: If `fail_set` is high in the same cycle that a report starts, that report shows the old code in byte 0 and the new code is kept for the next report.
- R9: On `cmd_begin`, `compl_byte` becomes the drive number in bits 7:5 with all other bits 0. Any `fail_set` ORs 0x02 into it and latches `fail_code`.
- R10: A `cmd_begin` with `cmd_sense` low sets the address-valid flag to `cmd_addr_en`. A `cmd_begin` with `cmd_sense` high leaves the flag unchanged.
- R11: A `rpt_start` that arrives while a report is in progress is ignored. The byte sequence carries on unchanged.
- R12: The drive number is latched on every `cmd_begin`. Head, sector and cylinder are latched only on a `cmd_begin` with `cmd_addr_en` high and `cmd_sense` low; otherwise they keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_begin | input | 1 | A new command starts this cycle |
| cmd_sense | input | 1 | The starting command is the sense request |
| cmd_addr_en | input | 1 | The starting command carries an address |
| cmd_drive | input | 3 | Drive number of the starting command |
| cmd_head | input | 5 | Head number of the starting command |
| cmd_sector | input | 6 | Sector number of the starting command |
| cmd_cyl | input | 10 | Cylinder of the starting command |
| fail_set | input | 1 | The current command failed this cycle |
| fail_code | input | 6 | Error code of the failure (class in bits 5:4) |
| rpt_start | input | 1 | Begin a four-byte sense report |
| rpt_take | input | 1 | The host takes the presented byte |
| rpt_valid | output | 1 | A report byte is presented |
| rpt_byte | output | 8 | Presented report byte |
| rpt_done | output | 1 | One-cycle pulse after the last byte is taken |
| compl_byte | output | 8 | Completion byte of the current command |

## Verification
The bench sweeps all 1024 cylinders with drive, head, sector and error code cycling alongside. A design that put the cylinder high bits in the wrong place, or that set the drive flag only for drive 1, would return wrong bytes 1 to 3. A failure reported in the same cycle as the report start is aimed at a latch that lets clear win: that latch would silently lose the new code. Further cases cover a long hold before a take, a restart during a report, and sense commands mixed with addressed and unaddressed commands. A sequencer that restarts, skips a byte or ignores the hold would return the wrong order. A flag or address latch that is too eager would show a stale or wrongly cleared valid bit or address.

// File: rtl/sense_pkg.sv
// Package: shared widths and types for the sense report generator.
// Assumes a 4-byte report whose field placement is fixed by the host software.
package sense_pkg;
    localparam int BYTE_W    = 8;
    localparam int DRV_W     = 3;
    localparam int HEAD_W    = 5;
    localparam int SEC_W     = 6;
    localparam int CYL_W     = 10;
    localparam int CYL_LO_W  = 8;
    localparam int CYL_HI_W  = CYL_W - CYL_LO_W;
    localparam int CODE_W    = 6;
    localparam int RPT_BYTES = 4;
    localparam int IDX_W     = $clog2(RPT_BYTES);

    localparam logic [BYTE_W-1:0] DRV_FLAG  = 8'h20;
    localparam logic [BYTE_W-1:0] FAIL_FLAG = 8'h02;

    typedef struct packed {
        logic [DRV_W-1:0]  drive;
        logic [HEAD_W-1:0] head;
        logic [SEC_W-1:0]  sector;
        logic [CYL_W-1:0]  cyl;
    } op_addr_t;

    typedef enum logic {SEQ_IDLE, SEQ_SEND} seq_state_e;
endpackage

// File: rtl/sense_err_latch.sv
// Module: sense_err_latch
// Holds the error code, the address-valid flag and the completion byte.
// Assumes fail_set refers to the command begun most recently; when a failure
// and a read-clear coincide, the failure wins.
module sense_err_latch
    import sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic              cmd_sense,
    input  logic              cmd_addr_en,
    input  logic [DRV_W-1:0]  cmd_drive,
    input  logic              fail_set,
    input  logic [CODE_W-1:0] fail_code,
    input  logic              clr_err,
    output logic [CODE_W-1:0] err_code,
    output logic              addr_ok,
    output logic [BYTE_W-1:0] compl_byte
);
    localparam int DRV_POS = BYTE_W - DRV_W;

    logic [BYTE_W-1:0] fail_bits;
    assign fail_bits = fail_set ? FAIL_FLAG : '0;

    // Error code: a new failure overrides the clear done by the first report byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_code <= '0;
        else if (fail_set) err_code <= fail_code;
        else if (clr_err)  err_code <= '0;
    end

    // Address-valid flag: rewritten by every command except the sense request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      addr_ok <= 1'b0;
        else if (cmd_begin && !cmd_sense) addr_ok <= cmd_addr_en;
    end

    // Completion byte: preset with the drive number, failure flag ORed in.
    always_ff @(posedge clk) begin
        if (!rst_n)         compl_byte <= '0;
        else if (cmd_begin) compl_byte <= {cmd_drive, {DRV_POS{1'b0}}} | fail_bits;
        else if (fail_set)  compl_byte <= compl_byte | FAIL_FLAG;
    end

    AST_NEW_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_set |=> err_code == $past(fail_code)); // R8
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err && !fail_set |=> err_code == '0); // R7
    AST_COMPL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fail_set |=> compl_byte[1]); // R9
    AST_SENSE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_begin && cmd_sense |=> addr_ok == $past(addr_ok)); // R10
endmodule

// File: rtl/sense_addr_latch.sv
// Module: sense_addr_latch
// Keeps the drive, head, sector and cylinder of the last operation.
// Assumes the drive is taken from every command and the rest only from
// commands that carry an address (the sense request never does).
module sense_addr_latch
    import sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic              cmd_sense,
    input  logic              cmd_addr_en,
    input  logic [DRV_W-1:0]  cmd_drive,
    input  logic [HEAD_W-1:0] cmd_head,
    input  logic [SEC_W-1:0]  cmd_sector,
    input  logic [CYL_W-1:0]  cmd_cyl,
    output op_addr_t          last_addr
);
    logic take_addr;
    assign take_addr = cmd_begin && cmd_addr_en && !cmd_sense;

    // Drive number: follows every command start.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_addr.drive <= '0;
        else if (cmd_begin) last_addr.drive <= cmd_drive;
    end

    // Head, sector, cylinder: captured only from addressed commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr.head   <= '0;
            last_addr.sector <= '0;
            last_addr.cyl    <= '0;
        end else if (take_addr) begin
            last_addr.head   <= cmd_head;
            last_addr.sector <= cmd_sector;
            last_addr.cyl    <= cmd_cyl;
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_begin |=> $stable(last_addr)); // R12
    AST_NONADDR_KEEPS_CYL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_begin && !cmd_addr_en |=> $stable(last_addr.cyl)); // R12
endmodule

// File: rtl/sense_byte_mux.sv
// Module: sense_byte_mux
// Builds the four report bytes from the latched state and selects one.
// Assumes head fits in 5 bits and the cylinder in 10 bits.
module sense_byte_mux
    import sense_pkg::*;
(
    input  logic              addr_ok,
    input  logic [CODE_W-1:0] err_code,
    input  op_addr_t          last_addr,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [BYTE_W-1:0] sel_byte
);
    logic [BYTE_W-1:0] rpt_bytes [RPT_BYTES];

    // One builder per byte position of the report.
    for (genvar g = 0; g < RPT_BYTES; g++) begin : g_byte
        if (g == 0) begin : g_err
            assign rpt_bytes[g] = {addr_ok, {(BYTE_W-1-CODE_W){1'b0}}, err_code};
        end else if (g == 1) begin : g_head
            assign rpt_bytes[g] = ((last_addr.drive != '0) ? DRV_FLAG : '0)
                                | {{(BYTE_W-HEAD_W){1'b0}}, last_addr.head};
        end else if (g == 2) begin : g_sect
            assign rpt_bytes[g] = {last_addr.cyl[CYL_W-1:CYL_LO_W], last_addr.sector};
        end else begin : g_cyl
            assign rpt_bytes[g] = last_addr.cyl[CYL_LO_W-1:0];
        end
    end

    // Byte selection for the sequencer.
    always_comb sel_byte = rpt_bytes[sel_idx];

    initial begin
        assert (SEC_W + CYL_HI_W == BYTE_W); // R4
    end
endmodule

// File: rtl/sense_report_seq.sv
// Module: sense_report_seq
// Steps through the report bytes, holding each until the host takes it.
// Assumes a start while busy is to be ignored.
module sense_report_seq
    import sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_start,
    input  logic              rpt_take,
    input  logic [BYTE_W-1:0] next_byte,
    output logic [IDX_W-1:0]  next_idx,
    output logic              clr_err,
    output logic              rpt_valid,
    output logic [BYTE_W-1:0] rpt_byte,
    output logic              rpt_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RPT_BYTES - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic              accept;

    assign accept    = rpt_start && (state == SEQ_IDLE);
    assign clr_err   = accept;
    assign rpt_valid = (state == SEQ_SEND);

    // Index of the byte to build next: 0 on a start, else one past the current.
    always_comb next_idx = (state == SEQ_IDLE) ? '0 : idx + 1'b1;

    // Sequencer: load byte 0 on start, advance on take, pulse done after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            idx      <= '0;
            rpt_byte <= '0;
            rpt_done <= 1'b0;
        end else begin
            rpt_done <= 1'b0;
            if (accept) begin
                state    <= SEQ_SEND;
                idx      <= '0;
                rpt_byte <= next_byte;
            end else if (state == SEQ_SEND && rpt_take) begin
                if (idx == LAST_IDX) begin
                    state    <= SEQ_IDLE;
                    rpt_done <= 1'b1;
                end else begin
                    idx      <= next_idx;
                    rpt_byte <= next_byte;
                end
            end
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !rpt_take |=> rpt_valid && $stable(rpt_byte)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_done |=> !rpt_done); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_done |-> !rpt_valid && $past(idx) == LAST_IDX); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && rpt_start && !rpt_take |=> idx == $past(idx)); // R11
endmodule

// File: rtl/sense_report_gen.sv
// Module: sense_report_gen (top)
// Latches error and address state of the last operation and serialises the
// four-byte sense report on request. Assumes the neighbouring command logic
// supplies one-cycle strobes.
module sense_report_gen
    import sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_begin,
    input  logic              cmd_sense,
    input  logic              cmd_addr_en,
    input  logic [DRV_W-1:0]  cmd_drive,
    input  logic [HEAD_W-1:0] cmd_head,
    input  logic [SEC_W-1:0]  cmd_sector,
    input  logic [CYL_W-1:0]  cmd_cyl,
    input  logic              fail_set,
    input  logic [CODE_W-1:0] fail_code,
    input  logic              rpt_start,
    input  logic              rpt_take,
    output logic              rpt_valid,
    output logic [BYTE_W-1:0] rpt_byte,
    output logic              rpt_done,
    output logic [BYTE_W-1:0] compl_byte
);
    logic [CODE_W-1:0] err_code;
    logic              addr_ok;
    logic              clr_err;
    op_addr_t          last_addr;
    logic [IDX_W-1:0]  next_idx;
    logic [BYTE_W-1:0] next_byte;

    sense_err_latch u_err (
        .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_sense(cmd_sense),
        .cmd_addr_en(cmd_addr_en), .cmd_drive(cmd_drive), .fail_set(fail_set),
        .fail_code(fail_code), .clr_err(clr_err), .err_code(err_code),
        .addr_ok(addr_ok), .compl_byte(compl_byte)
    );

    sense_addr_latch u_addr (
        .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_sense(cmd_sense),
        .cmd_addr_en(cmd_addr_en), .cmd_drive(cmd_drive), .cmd_head(cmd_head),
        .cmd_sector(cmd_sector), .cmd_cyl(cmd_cyl), .last_addr(last_addr)
    );

    sense_byte_mux u_mux (
        .addr_ok(addr_ok), .err_code(err_code), .last_addr(last_addr),
        .sel_idx(next_idx), .sel_byte(next_byte)
    );

    sense_report_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rpt_start(rpt_start), .rpt_take(rpt_take),
        .next_byte(next_byte), .next_idx(next_idx), .clr_err(clr_err),
        .rpt_valid(rpt_valid), .rpt_byte(rpt_byte), .rpt_done(rpt_done)
    );

    AST_FIRST_BYTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> rpt_byte[7] == $past(addr_ok)); // R2
endmodule

// File: tb/sense_report_gen_test.sv
// Bench: reference state kept in plain variables, expected bytes computed
// arithmetically. Inputs change and outputs are sampled on falling edges.
module sense_report_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_begin = 0, cmd_sense = 0, cmd_addr_en = 0;
    logic [2:0] cmd_drive = 0;
    logic [4:0] cmd_head = 0;
    logic [5:0] cmd_sector = 0;
    logic [9:0] cmd_cyl = 0;
    logic       fail_set = 0;
    logic [5:0] fail_code = 0;
    logic       rpt_start = 0, rpt_take = 0;
    logic       rpt_valid, rpt_done;
    logic [7:0] rpt_byte, compl_byte;

    int n_checks = 0, n_errors = 0;
    bit finished = 0;
    int ref_drive = 0, ref_head = 0, ref_sec = 0, ref_cyl = 0;
    int ref_code = 0, ref_valid = 0, ref_compl = 0;

    always #2 clk = ~clk;

    sense_report_gen uut (
        .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_sense(cmd_sense),
        .cmd_addr_en(cmd_addr_en), .cmd_drive(cmd_drive), .cmd_head(cmd_head),
        .cmd_sector(cmd_sector), .cmd_cyl(cmd_cyl), .fail_set(fail_set),
        .fail_code(fail_code), .rpt_start(rpt_start), .rpt_take(rpt_take),
        .rpt_valid(rpt_valid), .rpt_byte(rpt_byte), .rpt_done(rpt_done),
        .compl_byte(compl_byte)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int drv, input bit sense, input bit addr, input int hd,
                          input int sc, input int cy, input bit fail, input int code);
        cmd_begin = 1; cmd_sense = sense; cmd_addr_en = addr;
        cmd_drive = 3'(drv); cmd_head = 5'(hd); cmd_sector = 6'(sc); cmd_cyl = 10'(cy);
        fail_set = fail; fail_code = 6'(code);
        @(negedge clk);
        cmd_begin = 0; fail_set = 0;
        ref_drive = drv;
        if (!sense) begin
            ref_valid = addr;
            if (addr) begin ref_head = hd; ref_sec = sc; ref_cyl = cy; end
        end
        if (fail) ref_code = code;
        ref_compl = drv * 32 + (fail ? 2 : 0);
    endtask

    task automatic do_report(input string req, input bit fail_too, input int fcode,
                             input int hold, input bit restart);
        int exp[4];
        exp[0] = ref_valid * 128 + ref_code;
        exp[1] = ((ref_drive != 0) ? 32 : 0) + ref_head;
        exp[2] = (ref_cyl / 256) * 64 + ref_sec;
        exp[3] = ref_cyl % 256;
        rpt_start = 1; fail_set = fail_too; fail_code = 6'(fcode);
        @(negedge clk);
        rpt_start = 0; fail_set = 0;
        ref_code = fail_too ? fcode : 0;
        if (fail_too) ref_compl = ref_compl | 2;
        for (int i = 0; i < 4; i++) begin
            chk({req, " R5 valid"}, int'(rpt_valid), 1);
            chk($sformatf("%s byte%0d", req, i), int'(rpt_byte), exp[i]);
            for (int h = 0; h < hold; h++) begin
                rpt_start = restart;
                @(negedge clk);
                rpt_start = 0;
                chk($sformatf("R5/R11 hold byte%0d", i), int'(rpt_byte), exp[i]);
            end
            rpt_take = 1;
            @(negedge clk);
            rpt_take = 0;
        end
        chk({req, " R6 done"}, int'(rpt_done), 1);
        chk({req, " R6 valid low"}, int'(rpt_valid), 0);
        @(negedge clk);
        chk({req, " R6 done single"}, int'(rpt_done), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(rpt_valid), 0);
        chk("R1 done", int'(rpt_done), 0);
        chk("R1 compl", int'(compl_byte), 0);
        rst_n = 1;
        @(negedge clk);
        do_report("R1 zero report", 0, 0, 0, 0);

        // Addressed failing command, then a held report and a repeat (R2 R3 R4 R7 R9)
        do_cmd(3, 0, 1, 7, 12, 'h2A5, 1, 'h15);
        chk("R9 compl", int'(compl_byte), 'h62);
        do_report("R2 R3 R4 first", 0, 0, 3, 0);
        do_report("R7 cleared", 0, 0, 0, 0);

        // Unaddressed command clears the flag and keeps the address (R10 R12)
        do_cmd(0, 0, 0, 31, 63, 'h3FF, 0, 0);
        chk("R9 compl no fail", int'(compl_byte), 0);
        do_report("R10 R12 unaddressed", 0, 0, 0, 0);

        // Sense command keeps the flag (R10)
        do_cmd(5, 0, 1, 2, 3, 'h100, 1, 'h04);
        do_cmd(1, 1, 1, 9, 9, 9, 0, 0);
        chk("R9 sense compl", int'(compl_byte), 'h20);
        do_report("R10 sense keeps", 0, 0, 0, 0);

        // Failure coinciding with report start wins (R8), restart ignored (R11)
        do_cmd(2, 0, 1, 4, 5, 'h0C3, 1, 'h22);
        do_report("R8 old shown", 1, 'h21, 0, 0);
        chk("R8 compl", int'(compl_byte), 'h42);
        do_report("R8 new kept", 0, 0, 2, 1);

        // Sweep of all cylinders with cycling fields (R2 R3 R4 R9)
        for (int k = 0; k < 1024; k++) begin
            do_cmd(k % 8, 0, 1, k % 32, (k * 7) % 64, k, 1, (k / 4) % 64);
            chk($sformatf("R9 sweep compl k=%0d", k), int'(compl_byte), (k % 8) * 32 + 2);
            do_report("R2 R3 R4 sweep", 0, 0, 0, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule